// File: doc/BRIEF.md
# Two-Wide In-Order Issue Scheduler with Busy-Bit Readiness

This block is the scheduler inside one execution unit that runs a compiler-formed group of dependent instructions (a "braid") out of a plain FIFO. The distributor pushes instructions one per cycle. Each cycle, only the two oldest entries are examined. They leave strictly in program order towards two functional units, the younger only alongside the older.

A source operand either names an external (globally shared) register or an internal (braid-local) register.
- External readiness comes from a small busy vector with one bit per external register. A bit is raised when an instruction that writes that register is pushed. It is dropped by a writeback broadcast from any unit.
- Internal readiness comes from a valid mask. A bit is set when a completion carrying an internal result returns. It is cleared when a new internal producer of that register issues, and the whole mask is wiped when a braid's first instruction issues.

A braid's first instruction waits until every earlier instruction of the unit has completed. The unit reports idle when its FIFO is empty and nothing is in flight.

Instruction word, default widths (24 bits):
- bit 23: braid start
- [22:15]: opcode
- bit 14: source A used
- bit 13: A internal
- [12:10]: A index
- bit 9: source B used
- bit 8: B internal
- [7:5]: B index
- bit 4: write internal
- bit 3: write external
- [2:0]: destination index

Top module: `braid_issue_queue`

## Requirements
- R1: After reset the FIFO is empty, `idle` is 1, `full` is 0, no slot issues, all external registers read as not busy and the internal mask is all zero.
- R2: Instructions issue in push order. Slot 1 (bits [47:24] of `iss_word`, `iss_vld[1]`) carries the entry after slot 0 and is valid only when slot 0 issues in the same cycle. An entry behind a blocked head does not issue.
- R3: When both head entries are ready and independent, both issue in the same cycle.
- R4: Pushing an entry with write-external set marks that register busy from the next cycle. An entry reading it as an external source does not issue until a writeback broadcast of that tag. It issues at the earliest in the cycle after the broadcast cycle.
- R5: When a push allocating register r and a writeback of r occur in the same cycle, r stays busy.
- R6: An internal source is ready only once a completion with its internal flag and that tag has been accepted, and the bit counts from the next cycle. Issuing an instruction with write-internal clears its destination bit from the next cycle.
- R7: Slot 1 does not issue together with slot 0 when it reads, as an internal source, the internal destination of slot 0, even if the mask bit is set.
- R8: An entry with the start bit issues only from slot 0 and only when no instruction is in flight. Its issue clears the whole internal mask.
- R9: The FIFO holds DEPTH (32) entries. `full` is 1 exactly when it holds 32. A push while full is dropped and never issues.
- R10: `idle` is 1 exactly when the FIFO is empty and the count of issued but not completed instructions is zero. Each `cpl_vld` bit completes one instruction.
- R11: A source whose used bit is 0 never blocks issue, whatever its index and internal flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_vld | input | 1 | Push an instruction word |
| push_word | input | EW (24) | Instruction word to push |
| full | output | 1 | FIFO holds DEPTH entries |
| wb_vld | input | NWB (2) | Writeback broadcast valid per lane |
| wb_tag | input | NWB*XW (6) | External register tag per lane |
| cpl_vld | input | 2 | Completion from each functional unit |
| cpl_int | input | 2 | Completion wrote an internal register |
| cpl_tag | input | 2*IW (6) | Internal register tag per completion |
| iss_vld | output | 2 | Issue valid, bit 0 oldest |
| iss_word | output | 2*EW (48) | Issued words, slot 0 in low half |
| idle | output | 1 | Empty and nothing in flight |

## Verification
A wrong busy or mask bit shows at the ports within one cycle. It appears either as an issue whose external source was never freed by a broadcast, or as a head that stays blocked after the freeing event. A broken FIFO pointer or count shows as words leaving out of push order, a wrong `full`, or a dropped or duplicated word in the next drain. A wrong in-flight count shows as a braid start issuing early or stalling forever, or as `idle` disagreeing with the completions returned.

// File: rtl/braid_issue_queue.sv
module braid_issue_queue #(
  parameter int DEPTH = 32,
  parameter int XREGS = 8,
  parameter int IREGS = 8,
  parameter int OPW   = 8,
  parameter int NWB   = 2,
  localparam int XW = $clog2(XREGS),
  localparam int IW = $clog2(IREGS),
  localparam int SW = (XW > IW) ? XW : IW,
  localparam int EW = 3*SW + 7 + OPW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_vld,
  input  logic [EW-1:0]     push_word,
  output logic              full,
  input  logic [NWB-1:0]    wb_vld,
  input  logic [NWB*XW-1:0] wb_tag,
  input  logic [1:0]        cpl_vld,
  input  logic [1:0]        cpl_int,
  input  logic [2*IW-1:0]   cpl_tag,
  output logic [1:0]        iss_vld,
  output logic [2*EW-1:0]   iss_word,
  output logic              idle
);
  localparam int PW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int FW    = PW + 2;
  localparam int D_IDX = 0;
  localparam int D_EXT = SW;
  localparam int D_INT = SW + 1;
  localparam int B_IDX = SW + 2;
  localparam int B_INT = 2*SW + 2;
  localparam int B_USE = 2*SW + 3;
  localparam int A_IDX = 2*SW + 4;
  localparam int A_INT = 3*SW + 4;
  localparam int A_USE = 3*SW + 5;
  localparam int ST    = EW - 1;

  logic [EW-1:0]    mem [DEPTH];
  logic [PW-1:0]    rd, wr;
  logic [CW-1:0]    cnt;
  logic [FW-1:0]    infl;
  logic [XREGS-1:0] busy, busy_n;
  logic [IREGS-1:0] imask, imask_n;

  function automatic logic src_ok(input logic u, input logic i, input logic [SW-1:0] idx,
                                  input logic [XREGS-1:0] b, input logic [IREGS-1:0] m);
    return !u || (i ? m[idx[IW-1:0]] : !b[idx[XW-1:0]]);
  endfunction

  function automatic logic ent_ok(input logic [EW-1:0] w, input logic [XREGS-1:0] b,
                                  input logic [IREGS-1:0] m);
    return src_ok(w[A_USE], w[A_INT], w[A_IDX +: SW], b, m) &&
           src_ok(w[B_USE], w[B_INT], w[B_IDX +: SW], b, m);
  endfunction

  wire [EW-1:0] h0 = mem[rd];
  wire [EW-1:0] h1 = mem[rd + PW'(1)];

  wire dep = h0[D_INT] &&
    ((h1[A_USE] && h1[A_INT] && h1[A_IDX +: SW] == h0[D_IDX +: SW]) ||
     (h1[B_USE] && h1[B_INT] && h1[B_IDX +: SW] == h0[D_IDX +: SW]));

  wire go0 = (cnt != '0) && ent_ok(h0, busy, imask) && (!h0[ST] || infl == '0);
  wire go1 = go0 && (cnt >= CW'(2)) && !h1[ST] && !dep &&
             ent_ok(h1, busy, h0[ST] ? '0 : imask);

  wire       push_ok = push_vld && !full;
  wire [1:0] npop    = {1'b0, go0} + {1'b0, go1};
  wire [1:0] ncpl    = {1'b0, cpl_vld[0]} + {1'b0, cpl_vld[1]};

  assign full     = (cnt == CW'(DEPTH));
  assign idle     = (cnt == '0) && (infl == '0);
  assign iss_vld  = {go1, go0};
  assign iss_word = {h1, h0};

  always_comb begin
    busy_n = busy;
    for (int i = 0; i < NWB; i++)
      if (wb_vld[i]) busy_n[wb_tag[i*XW +: XW]] = 1'b0;
    if (push_ok && push_word[D_EXT]) busy_n[push_word[D_IDX +: XW]] = 1'b1;
  end

  always_comb begin
    imask_n = imask;
    if (go0 && h0[ST]) imask_n = '0;
    for (int i = 0; i < 2; i++)
      if (cpl_vld[i] && cpl_int[i]) imask_n[cpl_tag[i*IW +: IW]] = 1'b1;
    if (go0 && h0[D_INT]) imask_n[h0[D_IDX +: IW]] = 1'b0;
    if (go1 && h1[D_INT]) imask_n[h1[D_IDX +: IW]] = 1'b0;
  end

  always_ff @(posedge clk)
    if (push_ok) mem[wr] <= push_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd    <= '0;
      wr    <= '0;
      cnt   <= '0;
      infl  <= '0;
      busy  <= '0;
      imask <= '0;
    end else begin
      if (push_ok) wr <= wr + PW'(1);
      rd    <= rd + PW'(npop);
      cnt   <= cnt + CW'(push_ok) - CW'(npop);
      infl  <= infl + FW'(npop) - FW'(ncpl);
      busy  <= busy_n;
      imask <= imask_n;
    end
  end
endmodule

// File: rtl/braid_issue_queue_chk.sv
module braid_issue_queue_chk #(
  parameter int DEPTH = 32,
  parameter int XREGS = 8,
  parameter int IREGS = 8,
  parameter int OPW   = 8,
  parameter int NWB   = 2,
  localparam int XW = $clog2(XREGS),
  localparam int IW = $clog2(IREGS),
  localparam int SW = (XW > IW) ? XW : IW,
  localparam int EW = 3*SW + 7 + OPW
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push_vld,
  input logic [EW-1:0]     push_word,
  input logic              full,
  input logic [NWB-1:0]    wb_vld,
  input logic [NWB*XW-1:0] wb_tag,
  input logic [1:0]        cpl_vld,
  input logic [1:0]        iss_vld,
  input logic [2*EW-1:0]   iss_word,
  input logic              idle
);
  localparam int CW = $clog2(DEPTH + 1) + 1;
  localparam int ST = EW - 1;
  logic [XREGS-1:0] sbusy;
  logic [CW-1:0]    scnt;
  logic [CW+1:0]    sinfl;
  wire [EW-1:0] w0 = iss_word[EW-1:0];
  wire [EW-1:0] w1 = iss_word[2*EW-1:EW];
  wire acc = push_vld && !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sbusy <= '0;
      scnt  <= '0;
      sinfl <= '0;
    end else begin
      for (int i = 0; i < XREGS; i++) begin
        logic clr;
        clr = 1'b0;
        for (int k = 0; k < NWB; k++)
          if (wb_vld[k] && wb_tag[k*XW +: XW] == XW'(i)) clr = 1'b1;
        if (acc && push_word[SW] && push_word[XW-1:0] == XW'(i)) sbusy[i] <= 1'b1;
        else if (clr) sbusy[i] <= 1'b0;
      end
      scnt  <= scnt + CW'(acc) - CW'(iss_vld[0]) - CW'(iss_vld[1]);
      sinfl <= sinfl + (CW+2)'(iss_vld[0]) + (CW+2)'(iss_vld[1])
                     - (CW+2)'(cpl_vld[0]) - (CW+2)'(cpl_vld[1]);
    end
  end

  assert_pair_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    iss_vld[1] |-> iss_vld[0]);
  assert_ext_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
    iss_vld[0] |-> (!(w0[3*SW+5] && !w0[3*SW+4]) || !sbusy[w0[2*SW+4 +: XW]]) &&
                   (!(w0[2*SW+3] && !w0[2*SW+2]) || !sbusy[w0[SW+2 +: XW]]));
  assert_start_drained_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld[0] && w0[ST]) |-> sinfl == '0);
  assert_start_slot0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    iss_vld[1] |-> !w1[ST]);
  assert_full_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    full == (scnt == CW'(DEPTH)));
  assert_full_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_vld && iss_vld == 2'b00) |=> full);
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    idle == (scnt == '0 && sinfl == '0));
endmodule

bind braid_issue_queue braid_issue_queue_chk #(
  .DEPTH(DEPTH), .XREGS(XREGS), .IREGS(IREGS), .OPW(OPW), .NWB(NWB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .push_vld(push_vld), .push_word(push_word), .full(full),
  .wb_vld(wb_vld), .wb_tag(wb_tag), .cpl_vld(cpl_vld), .iss_vld(iss_vld),
  .iss_word(iss_word), .idle(idle)
);

// File: tb/braid_issue_queue_bench.sv
module braid_issue_queue_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_vld = 1'b0;
  logic [23:0] push_word = '0;
  logic        full;
  logic [1:0]  wb_vld = '0;
  logic [5:0]  wb_tag = '0;
  logic [1:0]  cpl_vld = '0;
  logic [1:0]  cpl_int = '0;
  logic [5:0]  cpl_tag = '0;
  logic [1:0]  iss_vld;
  logic [47:0] iss_word;
  logic        idle;
  int tests = 0, fails = 0;

  braid_issue_queue u_braid_issue_queue (
    .clk(clk), .rst_n(rst_n), .push_vld(push_vld), .push_word(push_word), .full(full),
    .wb_vld(wb_vld), .wb_tag(wb_tag), .cpl_vld(cpl_vld), .cpl_int(cpl_int),
    .cpl_tag(cpl_tag), .iss_vld(iss_vld), .iss_word(iss_word), .idle(idle)
  );

  always #5 clk = ~clk;

  function automatic logic [23:0] mk(input logic st, input logic [7:0] op,
      input logic au, input logic ai, input logic [2:0] a,
      input logic bu, input logic bi, input logic [2:0] b,
      input logic di, input logic de, input logic [2:0] d);
    return {st, op, au, ai, a, bu, bi, b, di, de, d};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
    push_vld = 1'b0; wb_vld = '0; cpl_vld = '0; cpl_int = '0;
    @(negedge clk);
  endtask

  task automatic push(input logic [23:0] w);
    push_vld = 1'b1; push_word = w;
  endtask

  task automatic wb(input logic [2:0] t);
    wb_vld = 2'b01; wb_tag = {3'd0, t};
  endtask

  task automatic cpl_i(input logic [2:0] t);
    cpl_vld = 2'b01; cpl_int = 2'b01; cpl_tag = {3'd0, t};
  endtask

  task automatic drain(input int n);
    while (n > 0) begin
      cpl_vld = (n >= 2) ? 2'b11 : 2'b01;
      n -= (n >= 2) ? 2 : 1;
      cyc();
    end
  endtask

  task automatic t_reset();
    chk("R1 idle", idle, 1);
    chk("R1 iss_vld", iss_vld, 0);
    chk("R1 full", full, 0);
  endtask

  task automatic t_dual();
    logic [23:0] b, c;
    push(mk(1, 8'd1, 0,0,0, 0,0,0, 0,1,3'd2)); cyc();
    chk("R8 start issues when drained", iss_vld, 2'b01);
    b = mk(0, 8'd2, 1,0,3'd2, 0,0,0, 0,0,0);
    c = mk(0, 8'd3, 0,0,0, 0,0,0, 0,0,0);
    push(b); cyc();
    chk("R4 blocked on busy", iss_vld, 0);
    push(c); cyc();
    chk("R2 younger waits behind head", iss_vld, 0);
    wb(3'd2); cyc();
    chk("R3 dual issue", iss_vld, 2'b11);
    chk("R2 slot order", iss_word, {c, b});
    cyc();
    chk("R10 busy while in flight", idle, 0);
    drain(3);
    chk("R10 idle after completions", idle, 1);
  endtask

  task automatic t_setwins();
    logic [23:0] e;
    push(mk(1, 8'd4, 0,0,0, 0,0,0, 0,1,3'd5)); wb(3'd5); cyc();
    chk("R5 producer issues", iss_vld, 2'b01);
    e = mk(0, 8'd5, 0,0,0, 1,0,3'd5, 0,0,0);
    push(e); cyc();
    chk("R5 set beats clear", iss_vld, 0);
    cyc();
    chk("R5 still busy", iss_vld, 0);
    wb(3'd5); cyc();
    chk("R5 freed by later broadcast", iss_word[23:0], e);
    drain(2);
  endtask

  task automatic t_internal();
    logic [23:0] g, h, k;
    push(mk(1, 8'd6, 0,0,0, 0,0,0, 1,0,3'd3)); cyc();
    chk("R6 producer issues", iss_vld, 2'b01);
    g = mk(0, 8'd7, 1,1,3'd3, 0,0,0, 0,0,0);
    push(g); cyc();
    chk("R6 internal not yet valid", iss_vld, 0);
    cpl_i(3'd3); cyc();
    chk("R6 ready after completion", {iss_vld, iss_word[23:0]}, {2'b01, g});
    push(mk(0, 8'd8, 0,0,0, 0,0,0, 0,1,3'd6)); cyc();
    chk("R3 lone ready head issues", iss_vld, 2'b01);
    h = mk(0, 8'd9, 1,0,3'd6, 0,0,0, 1,0,3'd3);
    k = mk(0, 8'd10, 1,1,3'd3, 0,0,0, 0,0,0);
    push(h); cyc();
    chk("R4 head blocked", iss_vld, 0);
    push(k); cyc();
    chk("R7 pair blocked behind head", iss_vld, 0);
    wb(3'd6); cyc();
    chk("R7 dependent not paired", {iss_vld, iss_word[23:0]}, {2'b01, h});
    cyc();
    chk("R6 issue cleared mask bit", iss_vld, 0);
    cpl_i(3'd3); cyc();
    chk("R6 ready after new completion", {iss_vld, iss_word[23:0]}, {2'b01, k});
    drain(3);
  endtask

  task automatic t_start();
    logic [23:0] t, s, z;
    push(mk(1, 8'd11, 0,0,0, 0,0,0, 0,1,3'd7)); cyc();
    t = mk(0, 8'd12, 1,0,3'd7, 0,0,0, 0,0,0);
    s = mk(1, 8'd13, 0,0,0, 0,0,0, 0,0,0);
    push(t); cyc();
    push(s); cyc();
    chk("R4 blocked", iss_vld, 0);
    wb(3'd7); cyc();
    chk("R8 start not in slot 1", {iss_vld, iss_word[23:0]}, {2'b01, t});
    cyc();
    chk("R8 start waits for in flight", iss_vld, 0);
    cpl_vld = 2'b01; cyc();
    chk("R8 still one in flight", iss_vld, 0);
    cpl_vld = 2'b01; cyc();
    chk("R8 start issues once drained", {iss_vld, iss_word[23:0]}, {2'b01, s});
    z = mk(0, 8'd14, 1,1,3'd3, 0,0,0, 0,0,0);
    push(z); cyc();
    chk("R8 start wiped internal mask", iss_vld, 0);
    cpl_i(3'd3); cyc();
    chk("R6 refilled mask", {iss_vld, iss_word[23:0]}, {2'b01, z});
    drain(1);
  endtask

  task automatic t_full();
    int nxt = 1;
    push(mk(1, 8'd15, 0,0,0, 0,0,0, 0,1,3'd1)); cyc();
    chk("R8 producer", iss_vld, 2'b01);
    push(mk(0, 8'd16, 0,0,3'd1, 0,1,3'd2, 0,0,0)); cyc();
    chk("R11 unused sources ignored", iss_vld, 2'b01);
    for (int i = 1; i <= 32; i++) begin
      push(mk(0, 8'(i), 1,0,3'd1, 0,0,0, 0,0,0)); cyc();
      if (i == 31) chk("R9 not full at 31", full, 0);
    end
    chk("R9 full at 32", full, 1);
    push(mk(0, 8'hEE, 0,0,0, 0,0,0, 0,0,0)); cyc();
    chk("R9 push while full keeps full", full, 1);
    chk("R9 full head still blocked", iss_vld, 0);
    wb(3'd1); cyc();
    for (int c = 0; c < 17; c++) begin
      if (iss_vld[0]) begin chk("R9 R2 drain order s0", iss_word[22:15], 8'(nxt)); nxt++; end
      if (iss_vld[1]) begin chk("R9 R2 drain order s1", iss_word[46:39], 8'(nxt)); nxt++; end
      cyc();
    end
    chk("R9 exactly 32 drained", nxt, 33);
    chk("R10 not idle", idle, 0);
    drain(34);
    chk("R10 idle at end", idle, 1);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dual();
    t_setwins();
    t_internal();
    t_start();
    t_full();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule